// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block governs the clock states of a small processor core. An 8-bit configuration byte, loaded through a plain write strobe, selects whether the internal clock runs at the input rate or at half of it, which low-power state a sleep request leads to, whether a bus request can be granted while the oscillator is off, and four reduced-drive selects that are passed straight out to the pad ring as static levels.

When the core reports that the second opcode of a sleep instruction has been fetched while its I/O-stop flag is set, the controller enters IDLE (oscillator running, core clock and clock output gated) or STANDBY (oscillator stopped). An interrupt request ends either state. IDLE resumes at once. STANDBY first restarts the oscillator and counts a stabilization window: `SLOW_WAIT` cycles normally, or 64 cycles in the quick-recovery variant. A bus request can also wake the oscillator out of STANDBY when allowed, and is granted only once that window has run out.

The outputs are enables for an external clock-gating cell and oscillator, not clocks. The write strobe and the core handshake inputs are single-cycle control pulses with no back-pressure.

Top module: `lp_clock_ctrl`

## Requirements
- R1: After reset every configuration bit is 0, the block is running, `osc_en` is 1, `div_by_one` is 0, all four `lodrv_*` outputs are 0 and `bus_ack_ok` follows `bus_req`.
- R2: While running, configuration bit 7 picks the rate: with 1 `core_clk_en` is high every cycle, with 0 it is high on every other cycle; `clkout_en` always equals `core_clk_en`.
- R3: The power-mode field is {bit 6, bit 3}: 01 selects IDLE, 10 STANDBY, 11 quick-recovery STANDBY; with 00 a sleep request leaves the block running.
- R4: A low-power state is entered only on a cycle where `sleep_fetched` and `io_stop` are both 1; `sleep_fetched` with `io_stop` at 0 has no effect.
- R5: In IDLE `osc_en` stays 1 while `core_clk_en` and `clkout_en` are 0.
- R6: In STANDBY `osc_en`, `core_clk_en` and `clkout_en` are all 0, and `bus_ack_ok` is 0 when bit 5 is 0.
- R7: An `irq_req` in IDLE restores the running state on the next clock edge, with no stabilization wait.
- R8: In quick-recovery STANDBY, after the edge that samples `irq_req`, `osc_en` is 1 with the core clock gated for exactly 64 cycles before `core_clk_en` returns.
- R9: In normal STANDBY that window is exactly `SLOW_WAIT` cycles.
- R10: With bit 5 set, a `bus_req` in STANDBY restarts the oscillator and `bus_ack_ok` rises only after the stabilization window, the core clock staying gated; dropping `bus_req` returns the block to STANDBY with the oscillator off.
- R11: Bits 4, 2, 1 and 0 drive `lodrv_clk`, `lodrv_sio`, `lodrv_cpu` and `lodrv_bus` as static levels.
- R12: While running or in IDLE, `bus_ack_ok` equals `bus_req`; `irq_req` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Load strobe for the configuration byte |
| cfg_wr_data | input | 8 | Configuration byte |
| sleep_fetched | input | 1 | Second opcode of a sleep instruction fetched |
| io_stop | input | 1 | Core I/O-stop flag |
| irq_req | input | 1 | Enabled interrupt request (exit condition) |
| bus_req | input | 1 | External bus request |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Internal clock enable |
| clkout_en | output | 1 | Clock output enable |
| bus_ack_ok | output | 1 | Bus acknowledge qualifier |
| div_by_one | output | 1 | Rate select, 1 = input rate |
| lodrv_clk | output | 1 | Reduced drive, clock output pad |
| lodrv_sio | output | 1 | Reduced drive, serial/timer pads |
| lodrv_cpu | output | 1 | Reduced drive, CPU control pads |
| lodrv_bus | output | 1 | Reduced drive, address/data pads |

## Verification
Random configuration bytes paired with random sleep and I/O-stop pulses separate the four mode-field codes and the gated entry condition, while counting enable pulses over a fixed window tells the two clock rates apart. Directed exits measure the gated window cycle by cycle, which distinguishes IDLE's immediate return from the 64-cycle and `SLOW_WAIT`-cycle restarts. Bus requests in STANDBY with bit 5 set and clear show whether a grant waits for the timer or is withheld, and a reset taken inside STANDBY shows the immediate return to the cleared running state.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_STBY    = 3'd2,
    ST_WAKE    = 3'd3,
    ST_BUSHOLD = 3'd4
  } lpc_state_e;

  // bit 7 first: packed struct order matches the byte
  typedef struct packed {
    logic div1;        // 7
    logic stby_sel;    // 6
    logic bus_in_stby; // 5
    logic lo_clk;      // 4
    logic idle_sel;    // 3
    logic lo_sio;      // 2
    logic lo_cpu;      // 1
    logic lo_bus;      // 0
  } lpc_cfg_t;
endpackage

// File: rtl/lpc_cfg_reg.sv
module lpc_cfg_reg
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output lpc_cfg_t   cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= lpc_cfg_t'(wr_data);
  end
endmodule

// File: rtl/lpc_stab_timer.sv
module lpc_stab_timer #(
  parameter int SLOW_WAIT  = 131072,
  parameter int QUICK_WAIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic quick,
  output logic done
);
  localparam int CW = $clog2(SLOW_WAIT + 1);
  localparam logic [CW-1:0] SLOW_LAST  = CW'(SLOW_WAIT - 1);
  localparam logic [CW-1:0] QUICK_LAST = CW'(QUICK_WAIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = quick ? QUICK_LAST : SLOW_LAST;
  assign done = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || done)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpc_mode_fsm.sv
module lpc_mode_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpc_cfg_t   cfg,
  input  logic       sleep_fetched,
  input  logic       io_stop,
  input  logic       irq_req,
  input  logic       bus_req,
  input  logic       timer_done,
  output lpc_state_e state_q,
  output logic       quick_q,
  output logic       timer_run
);
  lpc_state_e state_d;
  logic       quick_d;
  logic       wake_irq_q, wake_irq_d;
  logic [1:0] mode;

  assign mode      = {cfg.stby_sel, cfg.idle_sel};
  assign timer_run = (state_q == ST_WAKE);

  always_comb begin
    state_d    = state_q;
    quick_d    = quick_q;
    wake_irq_d = wake_irq_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_fetched && io_stop) begin
          unique case (mode)
            2'b01:        state_d = ST_IDLE;
            2'b10, 2'b11: begin
              state_d = ST_STBY;
              quick_d = mode[0];
            end
            default:      state_d = ST_RUN;
          endcase
        end
      end
      ST_IDLE:
        if (irq_req) state_d = ST_RUN;
      ST_STBY: begin
        if (irq_req) begin
          state_d    = ST_WAKE;
          wake_irq_d = 1'b1;
        end else if (cfg.bus_in_stby && bus_req) begin
          state_d    = ST_WAKE;
          wake_irq_d = 1'b0;
        end
      end
      ST_WAKE: begin
        if (irq_req) wake_irq_d = 1'b1;
        if (timer_done)
          state_d = (wake_irq_q || irq_req) ? ST_RUN : ST_BUSHOLD;
      end
      ST_BUSHOLD: begin
        if (irq_req)      state_d = ST_RUN;
        else if (!bus_req) state_d = ST_STBY;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      quick_q    <= 1'b0;
      wake_irq_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      quick_q    <= quick_d;
      wake_irq_q <= wake_irq_d;
    end
  end
endmodule

// File: rtl/lpc_clk_gate.sv
module lpc_clk_gate
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lpc_state_e state,
  input  logic       div1,
  output logic       osc_en,
  output logic       core_clk_en,
  output logic       clkout_en
);
  logic phase_q;
  logic running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign running     = (state == ST_RUN);
  assign osc_en      = (state != ST_STBY);
  assign core_clk_en = running && (div1 || phase_q);
  assign clkout_en   = running && (div1 || phase_q);
endmodule

// File: rtl/lp_clock_ctrl.sv
module lp_clock_ctrl
  import lpc_pkg::*;
#(
  parameter int SLOW_WAIT  = 131072,
  parameter int QUICK_WAIT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  input  logic       sleep_fetched,
  input  logic       io_stop,
  input  logic       irq_req,
  input  logic       bus_req,
  output logic       osc_en,
  output logic       core_clk_en,
  output logic       clkout_en,
  output logic       bus_ack_ok,
  output logic       div_by_one,
  output logic       lodrv_clk,
  output logic       lodrv_sio,
  output logic       lodrv_cpu,
  output logic       lodrv_bus
);
  lpc_cfg_t   cfg_q;
  lpc_state_e state_q;
  logic       quick_q, timer_run, timer_done;

  lpc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .cfg_q(cfg_q)
  );

  lpc_stab_timer #(.SLOW_WAIT(SLOW_WAIT), .QUICK_WAIT(QUICK_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .quick(quick_q), .done(timer_done)
  );

  lpc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .sleep_fetched(sleep_fetched),
    .io_stop(io_stop), .irq_req(irq_req), .bus_req(bus_req),
    .timer_done(timer_done), .state_q(state_q), .quick_q(quick_q),
    .timer_run(timer_run)
  );

  lpc_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state_q), .div1(cfg_q.div1),
    .osc_en(osc_en), .core_clk_en(core_clk_en), .clkout_en(clkout_en)
  );

  assign bus_ack_ok = bus_req && ((state_q == ST_RUN) || (state_q == ST_IDLE) ||
                                  (state_q == ST_BUSHOLD));
  assign div_by_one = cfg_q.div1;
  assign lodrv_clk  = cfg_q.lo_clk;
  assign lodrv_sio  = cfg_q.lo_sio;
  assign lodrv_cpu  = cfg_q.lo_cpu;
  assign lodrv_bus  = cfg_q.lo_bus;
endmodule

// File: rtl/lp_clock_ctrl_chk.sv
module lp_clock_ctrl_chk
  import lpc_pkg::*;
#(
  parameter int SLOW_WAIT = 131072
) (
  input logic       clk,
  input logic       rst_n,
  input lpc_state_e state,
  input lpc_cfg_t   cfg,
  input logic       sleep_fetched,
  input logic       io_stop,
  input logic       osc_en,
  input logic       core_clk_en,
  input logic       clkout_en,
  input logic       bus_req,
  input logic       bus_ack_ok,
  input logic       div_by_one
);
  localparam int LW = $clog2(SLOW_WAIT + 1) + 1;
  logic [LW-1:0] wake_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wake_len <= '0;
    else if (state != ST_WAKE) wake_len <= '0;
    else if (wake_len != '1)   wake_len <= wake_len + 1'b1;
  end

  assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_by_one && core_clk_en) |=> (!core_clk_en || div_by_one));

  assert_off_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !cfg.stby_sel && !cfg.idle_sel) |=> (state == ST_RUN));

  assert_entry_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !(sleep_fetched && io_stop)) |=> (state == ST_RUN));

  assert_idle_gating_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (osc_en && !core_clk_en && !clkout_en));

  assert_stby_gating_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STBY) |-> (!osc_en && !core_clk_en && !clkout_en));

  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> (wake_len < LW'(SLOW_WAIT)));

  assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_ok |-> bus_req);

  assert_restart_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !core_clk_en);
endmodule

bind lp_clock_ctrl lp_clock_ctrl_chk #(.SLOW_WAIT(SLOW_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .cfg(cfg_q),
  .sleep_fetched(sleep_fetched), .io_stop(io_stop), .osc_en(osc_en),
  .core_clk_en(core_clk_en), .clkout_en(clkout_en), .bus_req(bus_req),
  .bus_ack_ok(bus_ack_ok), .div_by_one(div_by_one)
);

// File: tb/lp_clock_ctrl_test.sv
module lp_clock_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 300;
  localparam int QUICK = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 0, sleep_fetched = 0, io_stop = 0, irq_req = 0, bus_req = 0;
  logic [7:0] cfg_wr_data = '0;
  logic osc_en, core_clk_en, clkout_en, bus_ack_ok, div_by_one;
  logic lodrv_clk, lodrv_sio, lodrv_cpu, lodrv_bus;
  int checks = 0, errors = 0;
  bit finished = 0;

  lp_clock_ctrl #(.SLOW_WAIT(SLOW), .QUICK_WAIT(QUICK)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .sleep_fetched(sleep_fetched), .io_stop(io_stop), .irq_req(irq_req),
    .bus_req(bus_req), .osc_en(osc_en), .core_clk_en(core_clk_en),
    .clkout_en(clkout_en), .bus_ack_ok(bus_ack_ok), .div_by_one(div_by_one),
    .lodrv_clk(lodrv_clk), .lodrv_sio(lodrv_sio), .lodrv_cpu(lodrv_cpu),
    .lodrv_bus(lodrv_bus)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic write_cfg(logic [7:0] b);
    cfg_wr_en = 1; cfg_wr_data = b; step(); cfg_wr_en = 0;
  endtask

  task automatic pulse_sleep(logic io);
    sleep_fetched = 1; io_stop = io; step(); sleep_fetched = 0; io_stop = 0;
  endtask

  task automatic pulse_irq();
    irq_req = 1; step(); irq_req = 0;
  endtask

  // 0 running, 1 idle, 2 standby
  function automatic int predict(logic [7:0] b, logic io);
    if (!io) return 0;
    case ({b[6], b[3]})
      2'b01:   return 1;
      2'b10, 2'b11: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int drv_bits(logic [7:0] b);
    return {b[4], b[2], b[1], b[0]};
  endfunction

  // count core enables (and mismatching clkout) over n samples
  task automatic count_en(int n, output int cnt, output int mism);
    cnt = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      if (core_clk_en) cnt++;
      if (clkout_en != core_clk_en) mism++;
      step();
    end
  endtask

  // samples with oscillator on and core gated before core clock returns
  task automatic measure_wake(output int n);
    n = 0;
    while (!core_clk_en && n < 2000) begin
      if (osc_en) n++;
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, m, n, k;
    logic [7:0] b;
    logic io;
    void'($urandom(32'd5150));
    step(); step(); rst_n = 1; step();

    // reset state
    check("R1 osc_en", osc_en, 1);
    check("R1 div_by_one", div_by_one, 0);
    check("R1 lodrv", {lodrv_clk, lodrv_sio, lodrv_cpu, lodrv_bus}, 0);
    bus_req = 1; #1;
    check("R1 bus_ack follows", bus_ack_ok, 1);
    bus_req = 0;
    count_en(8, c, m);
    check("R1 half rate after reset", c, 4);
    check("R2 clkout equals core", m, 0);

    // random configurations and sleep attempts
    for (int it = 0; it < 40; it++) begin
      b = 8'($urandom);
      io = 1'($urandom);
      write_cfg(b);
      check("R11 drive selects", {lodrv_clk, lodrv_sio, lodrv_cpu, lodrv_bus}, drv_bits(b));
      check("R2 rate bit", div_by_one, b[7]);
      count_en(8, c, m);
      check("R2 enable count", c, b[7] ? 8 : 4);
      check("R2 clkout equals core", m, 0);
      irq_req = 1; bus_req = 1; #1;
      check("R12 bus ack in run", bus_ack_ok, 1);
      step(); irq_req = 0; bus_req = 0;
      count_en(2, c, m);
      check("R12 irq in run ignored", c, b[7] ? 2 : 1);
      pulse_sleep(io);
      k = predict(b, io);
      check("R3 R4 osc after sleep", osc_en, (k == 2) ? 0 : 1);
      if (k != 0) check("R5 R6 core gated", core_clk_en, 0);
      if (k == 0) begin
        count_en(4, c, m);
        check("R3 R4 still running", c, b[7] ? 4 : 2);
      end else if (k == 1) begin
        bus_req = 1; #1;
        check("R12 bus ack in idle", bus_ack_ok, 1);
        bus_req = 0;
        pulse_irq();
        count_en(4, c, m);
        check("R7 idle resumes at once", c, b[7] ? 4 : 2);
      end else begin
        pulse_irq();
        measure_wake(n);
        if (b[7]) check(b[3] ? "R8 quick window" : "R9 slow window", n, b[3] ? QUICK : SLOW);
        else check("R8 R9 window (half rate)", (n == (b[3] ? QUICK : SLOW)) ||
                   (n == (b[3] ? QUICK : SLOW) + 1) ? 1 : 0, 1);
      end
    end

    // quick recovery, exact
    write_cfg(8'hC8); pulse_sleep(1);
    repeat (5) step();
    check("R6 standby osc off", osc_en, 0);
    pulse_irq(); measure_wake(n);
    check("R8 quick window exact", n, QUICK);

    // normal standby, exact
    write_cfg(8'hC0); pulse_sleep(1); pulse_irq(); measure_wake(n);
    check("R9 slow window exact", n, SLOW);

    // bus request in standby, allowed
    write_cfg(8'hE0); pulse_sleep(1);
    bus_req = 1; step();
    n = 0;
    while (!bus_ack_ok && n < 2000) begin
      if (osc_en && !core_clk_en) n++;
      step();
    end
    check("R10 grant after window", n, SLOW);
    check("R10 core still gated", core_clk_en, 0);
    check("R10 osc on during grant", osc_en, 1);
    bus_req = 0; step();
    check("R10 back to standby", osc_en, 0);
    pulse_irq(); measure_wake(n);
    check("R10 later irq exit", n, SLOW);

    // bus request in standby, not allowed
    write_cfg(8'hC0); pulse_sleep(1);
    bus_req = 1; m = 0;
    for (int i = 0; i < 400; i++) begin
      if (bus_ack_ok || osc_en) m++;
      step();
    end
    check("R6 R10 request withheld", m, 0);
    bus_req = 0;
    pulse_irq(); measure_wake(n);
    check("R9 exit after withheld request", n, SLOW);

    // explicit off mode and missing io_stop
    write_cfg(8'h80); pulse_sleep(1);
    count_en(4, c, m);
    check("R3 mode 00 keeps running", c, 4);
    write_cfg(8'hC0); pulse_sleep(0);
    count_en(4, c, m);
    check("R4 no io_stop keeps running", c, 4);

    // reset inside standby
    write_cfg(8'hDF); pulse_sleep(1);
    check("R6 standby entered", osc_en, 0);
    rst_n = 0; #1;
    check("R1 reset osc on", osc_en, 1);
    check("R1 reset clears drives", {lodrv_clk, lodrv_sio, lodrv_cpu, lodrv_bus}, 0);
    step(); rst_n = 1; step();
    count_en(8, c, m);
    check("R1 running half rate", c, 4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule